// File: doc/BRIEF.md
# Asynchronous HDLC Transmit Framer

This block turns a stream of frame payload bytes into the character stream for a start/stop (UART-type) transmitter. It wraps each frame in an opening flag and a closing flag. It appends a 16-bit frame check sequence (FCS). It applies byte transparency: any character that would confuse the receiver is replaced by an escape character and a modified copy of itself. When no frame is pending, it fills the line with idle characters. When a stop command arrives, it ends the frame in progress with an abort sequence.

Payload arrives on a valid/ready byte interface. Each byte carries three flags: one marking the last byte of a buffer, one marking the last buffer of a frame, and one asking for an interrupt. A further flag marks the buffer as continuous-mode. One frame may be split over several buffers. For every buffer that ends, the block emits a one-cycle completion strobe with status. The serial bit engine, memory fetching and descriptor storage lie outside this block.

Back-pressure rules are as follows. An output byte is transferred on a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_data` holds. `in_ready` depends combinationally on `out_ready` and on `stop_tx`. An input byte is consumed only on a cycle where `in_valid` and `in_ready` are both high. Producers must not wait for `in_ready` before raising `in_valid`.

Top module: `ahdlc_tx_framer`

## Requirements
- R1: While reset is held, `out_valid` is low. After reset, with no input pending, the block offers the idle character on every cycle the output accepts a byte. The idle character is 0xFF after reset.
- R2: Each frame starts with the opening flag, placed before its first payload byte. Each frame ends with the FCS followed by the closing flag. Both flags are 0x7E after reset.
- R3: The FCS is a CRC-16 with polynomial x^16+x^12+x^5+1. It is computed bit-reflected, from initial value 0xFFFF, over the unescaped payload bytes only. It is sent complemented, low byte first. The payload "123456789" gives the bytes 0x6E, 0x90.
- R4: A payload or FCS byte that equals the opening flag, the closing flag or the escape character is sent as two bytes: the escape character (0x7D after reset), then the byte XOR 0x20. A byte whose character-map bit is set is sent the same way.
- R5: The character map is 32 bits wide, and bit n covers character value n (0x00–0x1F). Bytes at or above 0x20 are escaped only if they match a flag or the escape character. The map is 0xFFFFFFFF after reset.
- R6: When `cfg_wr` is high, `cfg_wdata` is written into a configuration register chosen by `cfg_addr`. Address 0 is the opening flag, 1 the closing flag, 2 the escape character and 3 the idle character; these use bits 7:0. Address 4 is the character map (32 bits). Frames started after the write use the new values.
- R7: A buffer whose last byte has `in_last_frame` low is followed directly by the next buffer's payload within the same frame. No flag or FCS is placed between them.
- R8: When the last byte of a buffer is consumed, `buf_done` pulses in that same cycle, with `buf_aborted` low and `buf_keep` equal to `in_cont`. In that cycle `txb_event` equals `in_irq`. `txb_event` is low in every other cycle.
- R9: If `stop_tx` is high while a frame is in its payload phase, the rest of the frame is replaced by the escape character followed by the closing flag. No FCS is sent. `buf_done` pulses with `buf_aborted` high. While `stop_tx` stays high, `in_ready` is low and only idle characters follow.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. `in_ready` is high only in a cycle where the output register can take a new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| stop_tx | input | 1 | Stop command; aborts the current frame and holds off new ones |
| in_valid | input | 1 | Payload byte valid |
| in_ready | output | 1 | Payload byte accepted this cycle when valid |
| in_data | input | 8 | Payload byte |
| in_last_buf | input | 1 | Byte is the last of its buffer |
| in_last_frame | input | 1 | Buffer is the last of its frame (used with `in_last_buf`) |
| in_irq | input | 1 | Buffer requests an event on completion |
| in_cont | input | 1 | Buffer is continuous-mode (stays ready after sending) |
| out_valid | output | 1 | Output character valid |
| out_ready | input | 1 | Transmitter accepts a character |
| out_data | output | 8 | Output character |
| buf_done | output | 1 | Buffer completion strobe |
| buf_aborted | output | 1 | Completion status: the buffer was cut by an abort |
| buf_keep | output | 1 | Completion status: leave the buffer marked ready |
| txb_event | output | 1 | Transmit-buffer event (interrupt request) |

## Verification
A corrupted CRC register shows up only two to four characters after the frame's last payload byte, as wrong FCS bytes. Comparing whole frames against an independent model therefore catches it within the same frame. A wrong sequencer state shows sooner: a missing or doubled flag, an escape character without its partner, or a byte lost or repeated under back-pressure. Each of these breaks the next transfer at the output. Wrong completion status shows in the cycle the buffer's last byte is consumed. The bench checks the strobes in that same cycle.

// File: rtl/ahdlc_tx_pkg.sv
package ahdlc_tx_pkg;

  localparam int CHR_W = 8;
  localparam logic [CHR_W-1:0] ESC_XOR = 8'h20;
  localparam int CFG_AW = 3;

  typedef enum logic [CFG_AW-1:0] {
    CFG_OPEN  = 3'd0,
    CFG_CLOSE = 3'd1,
    CFG_ESC   = 3'd2,
    CFG_IDLE  = 3'd3,
    CFG_MAP   = 3'd4
  } cfg_addr_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_ESC2,
    ST_FCS_LO,
    ST_FCS_HI,
    ST_CLOSE,
    ST_ABORT
  } tx_state_e;

endpackage

// File: rtl/ahdlc_tx_cfg.sv
module ahdlc_tx_cfg
  import ahdlc_tx_pkg::*;
#(
  parameter int MAP_W = 32,
  parameter logic [CHR_W-1:0] OPEN_RST  = 8'h7E,
  parameter logic [CHR_W-1:0] CLOSE_RST = 8'h7E,
  parameter logic [CHR_W-1:0] ESC_RST   = 8'h7D,
  parameter logic [CHR_W-1:0] IDLE_RST  = 8'hFF,
  parameter logic [MAP_W-1:0] MAP_RST   = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CFG_AW-1:0] addr,
  input  logic [MAP_W-1:0]  wdata,
  output logic [CHR_W-1:0]  open_chr,
  output logic [CHR_W-1:0]  close_chr,
  output logic [CHR_W-1:0]  esc_chr,
  output logic [CHR_W-1:0]  idle_chr,
  output logic [MAP_W-1:0]  map
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_chr  <= OPEN_RST;
      close_chr <= CLOSE_RST;
      esc_chr   <= ESC_RST;
      idle_chr  <= IDLE_RST;
      map       <= MAP_RST;
    end else if (wr) begin
      case (addr)
        CFG_OPEN:  open_chr  <= wdata[CHR_W-1:0];
        CFG_CLOSE: close_chr <= wdata[CHR_W-1:0];
        CFG_ESC:   esc_chr   <= wdata[CHR_W-1:0];
        CFG_IDLE:  idle_chr  <= wdata[CHR_W-1:0];
        CFG_MAP:   map       <= wdata;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ahdlc_tx_esc.sv
module ahdlc_tx_esc
  import ahdlc_tx_pkg::*;
#(
  parameter int MAP_W = 32
) (
  input  logic [CHR_W-1:0] chr,
  input  logic [CHR_W-1:0] open_chr,
  input  logic [CHR_W-1:0] close_chr,
  input  logic [CHR_W-1:0] esc_chr,
  input  logic [MAP_W-1:0] map,
  output logic             need_esc
);

  localparam int IW = $clog2(MAP_W);

  logic in_map;
  assign in_map   = (chr < CHR_W'(MAP_W)) && map[chr[IW-1:0]];
  assign need_esc = in_map || (chr == open_chr) || (chr == close_chr) || (chr == esc_chr);

endmodule

// File: rtl/ahdlc_tx_crc.sv
module ahdlc_tx_crc
  import ahdlc_tx_pkg::*;
#(
  parameter int FCS_W = 16,
  parameter logic [FCS_W-1:0] POLY_R = 16'h8408,
  parameter logic [FCS_W-1:0] INIT   = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             en,
  input  logic [CHR_W-1:0] data,
  output logic [FCS_W-1:0] crc
);

  function automatic logic [FCS_W-1:0] step(input logic [FCS_W-1:0] c, input logic [CHR_W-1:0] d);
    logic [FCS_W-1:0] r;
    r = c ^ FCS_W'(d);
    for (int i = 0; i < CHR_W; i++)
      r = r[0] ? ((r >> 1) ^ POLY_R) : (r >> 1);
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)     crc <= INIT;
    else if (init)  crc <= INIT;
    else if (en)    crc <= step(crc, data);
  end

endmodule

// File: rtl/ahdlc_tx_framer.sv
module ahdlc_tx_framer
  import ahdlc_tx_pkg::*;
#(
  parameter int MAP_W = 32,
  parameter int FCS_W = 16,
  parameter logic [CHR_W-1:0] OPEN_RST  = 8'h7E,
  parameter logic [CHR_W-1:0] CLOSE_RST = 8'h7E,
  parameter logic [CHR_W-1:0] ESC_RST   = 8'h7D,
  parameter logic [CHR_W-1:0] IDLE_RST  = 8'hFF,
  parameter logic [MAP_W-1:0] MAP_RST   = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [MAP_W-1:0]  cfg_wdata,
  input  logic              stop_tx,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHR_W-1:0]  in_data,
  input  logic              in_last_buf,
  input  logic              in_last_frame,
  input  logic              in_irq,
  input  logic              in_cont,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CHR_W-1:0]  out_data,
  output logic              buf_done,
  output logic              buf_aborted,
  output logic              buf_keep,
  output logic              txb_event
);

  localparam int FCS_BYTES = FCS_W / CHR_W;

  logic [CHR_W-1:0] open_c, close_c, esc_c, idle_c;
  logic [MAP_W-1:0] map_c;
  logic [FCS_W-1:0] crc;
  logic [FCS_W-1:0] fcs;
  logic [CHR_W-1:0] fcs_byte [FCS_BYTES];

  tx_state_e        state_q, state_d, ret_q, ret_d;
  logic [CHR_W-1:0] hold_q, hold_d;
  logic             ov_q;
  logic [CHR_W-1:0] od_q;

  logic             adv, take, ld, crc_init, done_ok, done_abort, need_esc;
  logic [CHR_W-1:0] byte_d, cand;
  tx_state_e        target;

  ahdlc_tx_cfg #(
    .MAP_W(MAP_W), .OPEN_RST(OPEN_RST), .CLOSE_RST(CLOSE_RST),
    .ESC_RST(ESC_RST), .IDLE_RST(IDLE_RST), .MAP_RST(MAP_RST)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .open_chr(open_c), .close_chr(close_c), .esc_chr(esc_c), .idle_chr(idle_c), .map(map_c)
  );

  ahdlc_tx_crc #(.FCS_W(FCS_W)) u_crc (
    .clk(clk), .rst_n(rst_n), .init(crc_init), .en(take), .data(in_data), .crc(crc)
  );

  assign fcs = ~crc;
  for (genvar g = 0; g < FCS_BYTES; g++) begin : g_fcs
    assign fcs_byte[g] = fcs[g*CHR_W +: CHR_W];
  end

  always_comb begin
    case (state_q)
      ST_FCS_LO: cand = fcs_byte[0];
      ST_FCS_HI: cand = fcs_byte[FCS_BYTES-1];
      default:   cand = in_data;
    endcase
  end

  ahdlc_tx_esc #(.MAP_W(MAP_W)) u_esc (
    .chr(cand), .open_chr(open_c), .close_chr(close_c), .esc_chr(esc_c),
    .map(map_c), .need_esc(need_esc)
  );

  assign adv      = !ov_q || out_ready;
  assign in_ready = adv && (state_q == ST_DATA) && !stop_tx;
  assign take     = in_ready && in_valid;

  always_comb begin
    state_d    = state_q;
    ret_d      = ret_q;
    hold_d     = hold_q;
    ld         = 1'b0;
    byte_d     = od_q;
    crc_init   = 1'b0;
    done_ok    = 1'b0;
    done_abort = 1'b0;
    target     = ST_DATA;
    if (adv) begin
      case (state_q)
        ST_IDLE: begin
          ld = 1'b1;
          if (in_valid && !stop_tx) begin
            byte_d   = open_c;
            crc_init = 1'b1;
            state_d  = ST_DATA;
          end else begin
            byte_d = idle_c;
          end
        end
        ST_DATA: begin
          if (stop_tx) begin
            ld         = 1'b1;
            byte_d     = esc_c;
            done_abort = 1'b1;
            state_d    = ST_ABORT;
          end else if (in_valid) begin
            ld      = 1'b1;
            done_ok = in_last_buf;
            target  = (in_last_buf && in_last_frame) ? ST_FCS_LO : ST_DATA;
          end
        end
        ST_FCS_LO: begin ld = 1'b1; target = ST_FCS_HI; end
        ST_FCS_HI: begin ld = 1'b1; target = ST_CLOSE;  end
        ST_ESC2: begin
          ld      = 1'b1;
          byte_d  = hold_q;
          state_d = ret_q;
        end
        ST_CLOSE, ST_ABORT: begin
          ld      = 1'b1;
          byte_d  = close_c;
          state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
      // Shared transparency step for payload and FCS bytes
      if (ld && !done_abort && (state_q == ST_DATA || state_q == ST_FCS_LO || state_q == ST_FCS_HI)) begin
        if (need_esc) begin
          byte_d  = esc_c;
          hold_d  = cand ^ ESC_XOR;
          ret_d   = target;
          state_d = ST_ESC2;
        end else begin
          byte_d  = cand;
          state_d = target;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ret_q   <= ST_IDLE;
      hold_q  <= '0;
      ov_q    <= 1'b0;
      od_q    <= '0;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      hold_q  <= hold_d;
      if (adv) begin
        ov_q <= ld;
        if (ld) od_q <= byte_d;
      end
    end
  end

  assign out_valid   = ov_q;
  assign out_data    = od_q;
  assign buf_done    = done_ok || done_abort;
  assign buf_aborted = done_abort;
  assign buf_keep    = done_ok ? in_cont : (done_abort && in_valid && in_cont);
  assign txb_event   = done_ok && in_irq;

  // R10: a stalled output byte holds until taken
  p_out_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R10: input is accepted only when the output register can move
  p_in_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!out_valid || out_ready));

  // R4: the escape character is offered while its partner byte waits
  p_esc_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ESC2) |-> out_valid && (out_data == esc_c));

  // R9: abort begins with the escape character
  p_abort_esc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ABORT) |-> out_valid && (out_data == esc_c));

  // R8: an event only accompanies a normal buffer completion
  p_txb_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    txb_event |-> buf_done && !buf_aborted);

  // R3: the CRC does not move while its bytes are being sent
  p_fcs_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FCS_LO || state_q == ST_FCS_HI) |=> $stable(crc));

  // R2: the first byte of a frame is the opening flag
  p_open_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) && ($past(state_q) == ST_IDLE) |-> out_data == open_c);

endmodule

// File: tb/test_ahdlc_tx_framer.sv
`timescale 1ns/1ps
module test_ahdlc_tx_framer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        stop_tx = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_last_buf = 1'b0, in_last_frame = 1'b0, in_irq = 1'b0, in_cont = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_data;
  logic        buf_done, buf_aborted, buf_keep, txb_event;

  always #2 clk = ~clk;

  ahdlc_tx_framer i_ahdlc_tx_framer (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .stop_tx(stop_tx), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last_buf(in_last_buf), .in_last_frame(in_last_frame), .in_irq(in_irq), .in_cont(in_cont),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .buf_done(buf_done), .buf_aborted(buf_aborted), .buf_keep(buf_keep), .txb_event(txb_event)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [7:0]  m_open = 8'h7E, m_close = 8'h7E, m_esc = 8'h7D, m_idle = 8'hFF;
  logic [31:0] m_map = 32'hFFFF_FFFF;

  logic [7:0] cap[$];
  int   n_done = 0, n_txb = 0, n_abort = 0, n_stray_txb = 0, n_hold_bad = 0;
  bit   keeps[$];
  bit   bp_on = 0;
  logic prev_stall = 0;
  logic [7:0] prev_data = '0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Monitor at the falling edge, where all signals are settled
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall && !(out_valid && out_data == prev_data)) n_hold_bad++;
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (out_valid && out_ready) cap.push_back(out_data);
      if (buf_done) begin
        n_done++;
        keeps.push_back(buf_keep);
        if (buf_aborted) n_abort++;
      end
      if (txb_event) begin
        n_txb++;
        if (!buf_done) n_stray_txb++;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    out_ready = bp_on ? (($urandom % 3) != 0) : 1'b1;
  end

  function automatic logic [15:0] ref_crc(input logic [7:0] b[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (b[i]) begin
      c = c ^ {8'h00, b[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return ~c;
  endfunction

  function automatic bit ref_esc(input logic [7:0] b);
    return (b == m_open) || (b == m_close) || (b == m_esc) || (b < 8'h20 && m_map[b[4:0]]);
  endfunction

  function automatic void push_chr(ref logic [7:0] q[$], input logic [7:0] b);
    if (ref_esc(b)) begin q.push_back(m_esc); q.push_back(b ^ 8'h20); end
    else q.push_back(b);
  endfunction

  function automatic void build_frame(ref logic [7:0] q[$], input logic [7:0] b[$]);
    logic [15:0] f = ref_crc(b);
    q.delete();
    q.push_back(m_open);
    foreach (b[i]) push_chr(q, b[i]);
    push_chr(q, f[7:0]);
    push_chr(q, f[15:8]);
    q.push_back(m_close);
  endfunction

  task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, input bit lb, input bit lf, input bit irq, input bit cont);
    bit acc = 0;
    in_valid = 1'b1; in_data = d; in_last_buf = lb; in_last_frame = lf; in_irq = irq; in_cont = cont;
    while (!acc) begin
      @(negedge clk);
      acc = in_ready;
      @(posedge clk); #1;
    end
    in_valid = 1'b0; in_last_buf = 1'b0; in_last_frame = 1'b0; in_irq = 1'b0; in_cont = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] b[$]);
    foreach (b[i]) send_byte(b[i], i == b.size() - 1, i == b.size() - 1, 1'b0, 1'b0);
  endtask

  task automatic compare(input logic [7:0] exp[$], input string req, input string what);
    int s = 0, bad = -1;
    while (s < cap.size() && cap[s] == m_idle) s++;
    if (cap.size() < s + exp.size() + 1) begin
      chk(0, req, {what, " length"}, cap.size() - s, exp.size() + 1);
      return;
    end
    foreach (exp[i]) if (bad < 0 && cap[s+i] != exp[i]) bad = i;
    if (bad >= 0) chk(0, req, $sformatf("%s byte %0d", what, bad), cap[s+bad], exp[bad]);
    else chk(1, req, what, 0, 0);
    chk(cap[s+exp.size()] == m_idle, "R1", {what, " idle after frame"}, cap[s+exp.size()], m_idle);
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    wait_cycles(10);
    chk(cap.size() >= 8, "R1", "idle count", cap.size(), 8);
    foreach (cap[i]) if (cap[i] != 8'hFF) chk(0, "R1", "idle char", cap[i], 8'hFF);
    chk(cap.size() > 0 && cap[0] == 8'hFF, "R1", "first idle", cap.size() ? cap[0] : 0, 8'hFF);
  endtask

  task automatic t_basic;
    logic [7:0] b[$] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    logic [7:0] e[$];
    logic [15:0] f = ref_crc(b);
    chk(f == 16'h906E, "R3", "reference check value", f, 16'h906E);
    cap.delete();
    send_frame(b);
    wait_cycles(30);
    build_frame(e, b);
    compare(e, "R2", "basic frame");
    chk(e[10] == 8'h6E && e[11] == 8'h90, "R3", "fcs order", {e[10], e[11]}, 16'h6E90);
  endtask

  task automatic t_escape;
    logic [7:0] b[$] = '{8'h7E, 8'h7D, 8'h01, 8'h41, 8'h1F, 8'h20, 8'h00};
    logic [7:0] e[$];
    cap.delete();
    send_frame(b);
    wait_cycles(40);
    build_frame(e, b);
    compare(e, "R4", "escaped frame");
    chk(e[1] == 8'h7D && e[2] == 8'h5E, "R4", "flag transformed", {e[1], e[2]}, 16'h7D5E);
  endtask

  task automatic t_config;
    logic [7:0] b[$] = '{8'h01, 8'h02, 8'h7B, 8'h7E, 8'h7C, 8'h1F, 8'h55};
    logic [7:0] e[$];
    cfg_write(3'd4, 32'h0000_0002); m_map = 32'h0000_0002;
    cfg_write(3'd1, 32'h7B);        m_close = 8'h7B;
    cfg_write(3'd2, 32'h7C);        m_esc = 8'h7C;
    cfg_write(3'd3, 32'h55);        m_idle = 8'h55;
    cfg_write(3'd0, 32'h7A);        m_open = 8'h7A;
    cap.delete();
    wait_cycles(3);
    chk(cap.size() > 0 && cap[cap.size()-1] == 8'h55, "R6", "new idle char", cap.size() ? cap[cap.size()-1] : 0, 8'h55);
    send_frame(b);
    wait_cycles(40);
    build_frame(e, b);
    compare(e, "R6", "reconfigured frame");
    chk(e[1] == 8'h7C && e[2] == 8'h21, "R5", "map bit 1 escapes 0x01", {e[1], e[2]}, 16'h7C21);
    cfg_write(3'd0, 32'h7E); m_open = 8'h7E;
    cfg_write(3'd1, 32'h7E); m_close = 8'h7E;
    cfg_write(3'd2, 32'h7D); m_esc = 8'h7D;
    cfg_write(3'd3, 32'hFF); m_idle = 8'hFF;
    cfg_write(3'd4, 32'hFFFF_FFFF); m_map = 32'hFFFF_FFFF;
  endtask

  task automatic t_multibuf;
    logic [7:0] b[$] = '{8'h10, 8'h20, 8'h30, 8'h40, 8'h50, 8'h60};
    logic [7:0] e[$];
    cap.delete(); keeps.delete();
    n_done = 0; n_txb = 0; n_abort = 0;
    send_byte(8'h10, 0, 0, 0, 0); send_byte(8'h20, 1, 0, 0, 1);
    send_byte(8'h30, 0, 0, 0, 0); send_byte(8'h40, 1, 0, 1, 0);
    send_byte(8'h50, 0, 0, 0, 0); send_byte(8'h60, 1, 1, 0, 0);
    wait_cycles(30);
    build_frame(e, b);
    compare(e, "R7", "three-buffer frame");
    chk(n_done == 3, "R8", "done strobes", n_done, 3);
    chk(n_txb == 1, "R8", "event count", n_txb, 1);
    chk(n_abort == 0, "R8", "no aborted status", n_abort, 0);
    chk(keeps.size() == 3 && keeps[0] && !keeps[1] && !keeps[2], "R8", "keep flags",
        keeps.size() == 3 ? {keeps[0], keeps[1], keeps[2]} : 7, 3'b100);
  endtask

  task automatic t_backpressure;
    logic [7:0] b[$];
    logic [7:0] e[$];
    for (int i = 0; i < 24; i++) b.push_back(8'(i * 11 + 3));
    n_hold_bad = 0;
    cap.delete();
    bp_on = 1;
    send_frame(b);
    wait_cycles(120);
    bp_on = 0;
    wait_cycles(4);
    build_frame(e, b);
    compare(e, "R10", "frame under back-pressure");
    chk(n_hold_bad == 0, "R10", "stalled byte held", n_hold_bad, 0);
    chk(n_stray_txb == 0, "R8", "event without done", n_stray_txb, 0);
  endtask

  task automatic t_abort;
    logic [7:0] e[$];
    logic [7:0] one[$] = '{8'hA5};
    int s = 0, seen_rdy = 0;
    cap.delete(); n_done = 0; n_abort = 0;
    send_byte(8'h41, 0, 0, 0, 0);
    send_byte(8'h7E, 0, 0, 0, 0);
    send_byte(8'h43, 0, 0, 0, 0);
    stop_tx = 1'b1;
    wait_cycles(10);
    e = '{8'h7E, 8'h41, 8'h7D, 8'h5E, 8'h43, 8'h7D, 8'h7E};
    compare(e, "R9", "aborted frame");
    chk(n_done == 1 && n_abort == 1, "R9", "abort status strobe", {n_done[3:0], n_abort[3:0]}, 8'h11);
    cap.delete();
    in_valid = 1'b1; in_data = 8'hA5; in_last_buf = 1'b1; in_last_frame = 1'b1;
    repeat (12) begin
      @(negedge clk);
      if (in_ready) seen_rdy++;
    end
    chk(seen_rdy == 0, "R9", "in_ready while stopped", seen_rdy, 0);
    foreach (cap[i]) if (cap[i] != 8'hFF) s++;
    chk(s == 0 && cap.size() > 0, "R9", "only idle while stopped", s, 0);
    @(posedge clk); #1;
    stop_tx = 1'b0;
    cap.delete();
    send_byte(8'hA5, 1, 1, 0, 0);
    wait_cycles(20);
    build_frame(e, one);
    compare(e, "R2", "frame after stop released");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_escape();
    t_config();
    t_multibuf();
    t_backpressure();
    t_abort();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule